// File: doc/BRIEF.md
# Dual-Loop Phase Comparator with Lock Judge

This block compares the phase of two synthesizer loops. For each loop it takes a reference strobe and a divided-feedback strobe, both synchronous to the oscillator clock `clk`. It produces a pump command on two wires. `pump_up` asks the charge pump to source current (drive high) and `pump_dn` asks it to sink current (drive low). When neither is set the pump output floats at high impedance. A per-loop polarity bit swaps the two commands, so that loops with an inverted VCO slope can be handled.

A lock judge runs beside each comparator. It measures the phase error of every finished comparison in oscillator periods. It drops lock at once on a large error. It grants lock only after a run of small errors. A power-down input per loop idles that loop's pump and makes its lock flag read as locked. One shared output pin carries one of two things: the AND of both lock flags, or a raw reference or feedback strobe of either loop for probing.

Top module: `pfd_lock_pair`

## Requirements
- R1: With `fc_pol` high, a reference rising edge sampled d cycles before the feedback rising edge gives d cycles of `pump_up` alone, then one cycle of both. A feedback edge that leads gives d cycles of `pump_dn` alone, then one cycle of both. `pump_up` first rises in the cycle after the leading edge is sampled.
- R2: With `fc_pol` low, the roles of `pump_up` and `pump_dn` in R1 are exchanged.
- R3: Every comparison ends with exactly one cycle in which `pump_up` and `pump_dn` are both high, followed by a cycle with both low. When the two edges are sampled on the same clock edge, only that one-cycle pulse pair is produced.
- R4: While one command is pending, further rising edges on the leading input are ignored. The phase error keeps counting from the first edge.
- R5: A finished comparison whose error is UNLOCK_MIN (default 4) periods or more clears the loop's lock in the cycle that follows.
- R6: Lock is granted after PERSIST (default 3) consecutive finished comparisons with error of LOCK_MAX (default 3, at most 8) periods or less. A zero-error comparison counts toward the run. A comparison with a larger error restarts the run.
- R7: With `pwr_on` low, the loop's pump wires are both low from the next cycle on, and its edges are ignored. Its lock flag reads 1. On release, the loop starts unlocked with its run count at zero.
- R8: With `mon_en` low, `share_out` is the AND of the two loops' lock flags.
- R9: With `mon_en` high, `share_out` shows a raw input strobe. `mon_pick` 00 selects reference 0, 01 selects reference 1, 10 selects feedback 0 and 11 selects feedback 1. Bit 0 picks the loop and bit 1 picks feedback.
- R10: After reset both pumps are idle and both loops are unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; also the unit of phase error |
| rst_n | input | 1 | Asynchronous reset, active low |
| fr_in | input | 2 | Reference strobe per loop (rising edge used) |
| fp_in | input | 2 | Divided feedback strobe per loop (rising edge used) |
| fc_pol | input | 2 | Pump polarity per loop; 1 = reference lead drives high |
| pwr_on | input | 2 | 1 = loop active, 0 = power-down |
| mon_en | input | 1 | 1 = monitor strobe on share_out, 0 = combined lock |
| mon_pick | input | 2 | Monitor selection, see R9 |
| pump_up | output | 2 | Source-current command per loop |
| pump_dn | output | 2 | Sink-current command per loop |
| share_out | output | 1 | Shared lock / monitor output |

## Verification
The assertions take for granted that the strobes are synchronous to `clk`. They also assume that no new rising edge lands in the single cycle in which a comparison is being cleared, and that the polarity bit is steady while a comparison is open. The bench respects all three. Each comparison is driven on falling clock edges, and both strobes are held until the comparison has closed. Both strobes are then lowered and one idle cycle is inserted before the next edge. Polarity and power-down changes are made only between comparisons.

// File: rtl/pfdl_pkg.sv
`timescale 1ns/1ps
package pfdl_pkg;

  typedef struct packed {
    logic src;
    logic snk;
  } pump_cmd_t;

  typedef enum logic [1:0] {
    V_HOLD = 2'b00,
    V_GOOD = 2'b01,
    V_BAD  = 2'b10
  } verdict_e;

  // Translate the comparator state into source/sink wires under polarity.
  function automatic pump_cmd_t map_pump(input logic ref_side, input logic fb_side,
                                         input logic pol);
    pump_cmd_t c;
    c.src = pol ? ref_side : fb_side;
    c.snk = pol ? fb_side  : ref_side;
    return c;
  endfunction

  // Classify one finished comparison by its error in clock periods.
  function automatic verdict_e judge_err(input int err, input int unlock_min,
                                         input int lock_max);
    if (err >= unlock_min) return V_BAD;
    if (err <= lock_max)   return V_GOOD;
    return V_HOLD;
  endfunction

endpackage

// File: rtl/pfd_core.sv
`timescale 1ns/1ps
module pfd_core
  import pfdl_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fc,
  input  logic             fr,
  input  logic             fp,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             cmp_done,
  output logic [ERR_W-1:0] err_val
);
  localparam logic [ERR_W-1:0] ERR_TOP = {ERR_W{1'b1}};

  logic             fr_d, fp_d;
  logic             ref_q, fb_q;
  logic [ERR_W-1:0] span_q;
  logic             fr_rise, fp_rise, overlap, single;
  pump_cmd_t        cmd;

  assign fr_rise = fr & ~fr_d;
  assign fp_rise = fp & ~fp_d;
  assign overlap = ref_q & fb_q;
  assign single  = ref_q ^ fb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_d   <= 1'b0;
      fp_d   <= 1'b0;
      ref_q  <= 1'b0;
      fb_q   <= 1'b0;
      span_q <= '0;
    end else begin
      fr_d <= fr;
      fp_d <= fp;
      if (!run || overlap) begin
        ref_q  <= 1'b0;
        fb_q   <= 1'b0;
        span_q <= '0;
      end else begin
        ref_q <= ref_q | fr_rise;
        fb_q  <= fb_q  | fp_rise;
        if (single && span_q != ERR_TOP) span_q <= span_q + 1'b1;
      end
    end
  end

  assign cmd      = map_pump(ref_q, fb_q, fc);
  assign pump_up  = cmd.src;
  assign pump_dn  = cmd.snk;
  assign cmp_done = overlap & run;
  assign err_val  = span_q;
endmodule

// File: rtl/lock_judge.sv
`timescale 1ns/1ps
module lock_judge
  import pfdl_pkg::*;
#(
  parameter int ERR_W      = 8,
  parameter int UNLOCK_MIN = 4,
  parameter int LOCK_MAX   = 3,
  parameter int PERSIST    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cmp_done,
  input  logic [ERR_W-1:0] err_val,
  output logic             lock_held,
  output logic             lock_flag
);
  localparam int              RUN_W    = $clog2(PERSIST + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(PERSIST - 1);

  logic [RUN_W-1:0] run_q;
  logic             held_q;
  verdict_e         verdict;

  assign verdict = judge_err(int'(err_val), UNLOCK_MIN, LOCK_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      held_q <= 1'b0;
    end else if (!run) begin
      run_q  <= '0;
      held_q <= 1'b0;
    end else if (cmp_done) begin
      unique case (verdict)
        V_BAD: begin
          run_q  <= '0;
          held_q <= 1'b0;
        end
        V_GOOD: begin
          if (run_q >= RUN_LAST) held_q <= 1'b1;
          else                   run_q  <= run_q + 1'b1;
        end
        default: run_q <= '0;
      endcase
    end
  end

  assign lock_held = held_q;
  assign lock_flag = run ? held_q : 1'b1;
endmodule

// File: rtl/share_sel.sv
`timescale 1ns/1ps
module share_sel (
  input  logic       mon_en,
  input  logic [1:0] mon_pick,
  input  logic [1:0] fr,
  input  logic [1:0] fp,
  input  logic [1:0] lock_flag,
  output logic       share_out
);
  always_comb begin
    if (mon_en) begin
      unique case (mon_pick)
        2'b00:   share_out = fr[0];
        2'b01:   share_out = fr[1];
        2'b10:   share_out = fp[0];
        default: share_out = fp[1];
      endcase
    end else begin
      share_out = &lock_flag;
    end
  end
endmodule

// File: rtl/pfd_lock_pair.sv
`timescale 1ns/1ps
module pfd_lock_pair #(
  parameter int ERR_W      = 8,
  parameter int UNLOCK_MIN = 4,
  parameter int LOCK_MAX   = 3,
  parameter int PERSIST    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fr_in,
  input  logic [1:0] fp_in,
  input  logic [1:0] fc_pol,
  input  logic [1:0] pwr_on,
  input  logic       mon_en,
  input  logic [1:0] mon_pick,
  output logic [1:0] pump_up,
  output logic [1:0] pump_dn,
  output logic       share_out
);
  localparam int LOOPS = 2;

  logic [LOOPS-1:0]            cmp_done;
  logic [LOOPS-1:0][ERR_W-1:0] err_val;
  logic [LOOPS-1:0]            lock_held;
  logic [LOOPS-1:0]            lock_flag;

  for (genvar g = 0; g < LOOPS; g++) begin : g_loop
    pfd_core #(.ERR_W(ERR_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (pwr_on[g]),
      .fc       (fc_pol[g]),
      .fr       (fr_in[g]),
      .fp       (fp_in[g]),
      .pump_up  (pump_up[g]),
      .pump_dn  (pump_dn[g]),
      .cmp_done (cmp_done[g]),
      .err_val  (err_val[g])
    );
    lock_judge #(
      .ERR_W(ERR_W), .UNLOCK_MIN(UNLOCK_MIN), .LOCK_MAX(LOCK_MAX), .PERSIST(PERSIST)
    ) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (pwr_on[g]),
      .cmp_done  (cmp_done[g]),
      .err_val   (err_val[g]),
      .lock_held (lock_held[g]),
      .lock_flag (lock_flag[g])
    );
  end

  share_sel u_share (
    .mon_en    (mon_en),
    .mon_pick  (mon_pick),
    .fr        (fr_in),
    .fp        (fp_in),
    .lock_flag (lock_flag),
    .share_out (share_out)
  );
endmodule

// File: rtl/pfd_lock_pair_chk.sv
`timescale 1ns/1ps
module pfd_lock_pair_chk #(
  parameter int ERR_W      = 8,
  parameter int UNLOCK_MIN = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            pwr_on,
  input logic                  mon_en,
  input logic [1:0]            pump_up,
  input logic [1:0]            pump_dn,
  input logic                  share_out,
  input logic [1:0]            cmp_done,
  input logic [1:0][ERR_W-1:0] err_val,
  input logic [1:0]            lock_held
);
  for (genvar g = 0; g < 2; g++) begin : g_chk
    assert_pair_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pump_up[g] && pump_dn[g]) |=> (!pump_up[g] && !pump_dn[g]));

    assert_psave_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on[g] |=> (!pump_up[g] && !pump_dn[g]));

    assert_big_error_unlocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on[g] && cmp_done[g] && int'(err_val[g]) >= UNLOCK_MIN) |=> !lock_held[g]);

    assert_lock_on_compare_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_held[g]) |-> $past(cmp_done[g]));
  end

  assert_both_down_share_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && pwr_on == 2'b00) |-> share_out);
endmodule

bind pfd_lock_pair pfd_lock_pair_chk #(.ERR_W(ERR_W), .UNLOCK_MIN(UNLOCK_MIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_on    (pwr_on),
  .mon_en    (mon_en),
  .pump_up   (pump_up),
  .pump_dn   (pump_dn),
  .share_out (share_out),
  .cmp_done  (cmp_done),
  .err_val   (err_val),
  .lock_held (lock_held)
);

// File: tb/tb_pfd_lock_pair.sv
`timescale 1ns/1ps
module tb_pfd_lock_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fr_in = 2'b00, fp_in = 2'b00, fc_pol = 2'b11, pwr_on = 2'b00;
  logic       mon_en = 1'b0;
  logic [1:0] mon_pick = 2'b00;
  logic [1:0] pump_up, pump_dn;
  logic       share_out;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int    hi;
    int    lo;
    string tag;
  } exp_t;
  exp_t q0[$];
  exp_t q1[$];
  int   run_hi [2] = '{0, 0};
  int   run_lo [2] = '{0, 0};

  always #4 clk = ~clk;

  pfd_lock_pair dut (
    .clk(clk), .rst_n(rst_n), .fr_in(fr_in), .fp_in(fp_in), .fc_pol(fc_pol),
    .pwr_on(pwr_on), .mon_en(mon_en), .mon_pick(mon_pick),
    .pump_up(pump_up), .pump_dn(pump_dn), .share_out(share_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: counts drive-only cycles per loop and pops the expectation at the pair cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        if (pump_up[i] && pump_dn[i]) begin
          exp_t e;
          if (i == 0 ? q0.size() == 0 : q1.size() == 0) begin
            chk("R3 unexpected pair", 1, 0);
          end else begin
            e = (i == 0) ? q0.pop_front() : q1.pop_front();
            chk({e.tag, " drive-high cycles"}, run_hi[i], e.hi);
            chk({e.tag, " drive-low cycles"},  run_lo[i], e.lo);
          end
          run_hi[i] = 0;
          run_lo[i] = 0;
        end else if (pump_up[i]) begin
          run_hi[i]++;
        end else if (pump_dn[i]) begin
          run_lo[i]++;
        end
      end
    end
  end

  // Driver: one comparison on loop lp; the leading strobe comes d cycles early.
  task automatic compare(input int lp, input bit fr_first, input int d);
    exp_t e;
    if (d == 0) begin
      e.hi = 0; e.lo = 0; e.tag = "R3";
    end else if (fr_first == fc_pol[lp]) begin
      e.hi = d; e.lo = 0; e.tag = fc_pol[lp] ? "R1" : "R2";
    end else begin
      e.hi = 0; e.lo = d; e.tag = fc_pol[lp] ? "R1" : "R2";
    end
    if (lp == 0) q0.push_back(e); else q1.push_back(e);
    @(negedge clk);
    if (d == 0) begin
      fr_in[lp] = 1'b1; fp_in[lp] = 1'b1;
    end else begin
      if (fr_first) fr_in[lp] = 1'b1; else fp_in[lp] = 1'b1;
      repeat (d) @(negedge clk);
      if (fr_first) fp_in[lp] = 1'b1; else fr_in[lp] = 1'b1;
    end
    repeat (3) @(negedge clk);
    fr_in[lp] = 1'b0; fp_in[lp] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 pump_up idle", int'(pump_up), 0);
    chk("R10 pump_dn idle", int'(pump_dn), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 both powered down reads locked", share_out, 1);
    pwr_on = 2'b01;
    @(negedge clk);
    chk("R10 loop 0 unlocked after reset", share_out, 0);

    // Loop 0, polarity high.
    compare(0, 1, 2); chk("R6 one good", share_out, 0);
    compare(0, 1, 2); chk("R6 two good", share_out, 0);
    compare(0, 1, 2); chk("R6 three good locks", share_out, 1);
    compare(0, 1, 0); chk("R3 zero error keeps lock", share_out, 1);
    compare(0, 0, 5); chk("R5 error 5 unlocks", share_out, 0);

    // Polarity low, boundary errors.
    fc_pol[0] = 1'b0;
    compare(0, 1, 3); compare(0, 1, 3);
    chk("R6 two at limit", share_out, 0);
    compare(0, 1, 3); chk("R6 error 3 qualifies", share_out, 1);
    compare(0, 1, 4); chk("R5 error 4 unlocks", share_out, 0);
    compare(0, 0, 1);
    compare(0, 1, 6); chk("R6 bad result restarts run", share_out, 0);
    compare(0, 1, 2); compare(0, 1, 2);
    chk("R6 run of two after restart", share_out, 0);
    compare(0, 1, 0); chk("R6 zero-error pair counts", share_out, 1);

    // R4: a second reference edge while pending is ignored.
    begin
      exp_t e;
      e.hi = 0; e.lo = 5; e.tag = "R4";
      q0.push_back(e);
      @(negedge clk); fr_in[0] = 1'b1;
      @(negedge clk); fr_in[0] = 1'b0;
      @(negedge clk); fr_in[0] = 1'b1;
      repeat (3) @(negedge clk); fp_in[0] = 1'b1;
      repeat (3) @(negedge clk); fr_in[0] = 1'b0; fp_in[0] = 1'b0;
      @(negedge clk);
      chk("R4 error counted from first edge unlocks", share_out, 0);
    end

    // R7: power-down ignores edges.
    pwr_on = 2'b00;
    @(negedge clk);
    chk("R7 lock flags read 1", share_out, 1);
    fr_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 pump_up quiet", int'(pump_up), 0);
    chk("R7 pump_dn quiet", int'(pump_dn), 0);
    fr_in[0] = 1'b0;
    @(negedge clk);

    // R9: monitor selection under two patterns.
    mon_en = 1'b1;
    fr_in = 2'b01; fp_in = 2'b10;
    for (int s = 0; s < 4; s++) begin
      mon_pick = 2'(s);
      #1;
      chk("R9 pattern A", share_out, (s == 0 || s == 3) ? 1 : 0);
    end
    fr_in = 2'b10; fp_in = 2'b01;
    for (int s = 0; s < 4; s++) begin
      mon_pick = 2'(s);
      #1;
      chk("R9 pattern B", share_out, (s == 1 || s == 2) ? 1 : 0);
    end
    @(negedge clk);
    fr_in = 2'b00; fp_in = 2'b00; mon_en = 1'b0;
    @(negedge clk);

    // Loop 1 lock, then combine with loop 0.
    pwr_on = 2'b10; fc_pol[1] = 1'b1;
    @(negedge clk);
    compare(1, 1, 1); compare(1, 0, 1); compare(1, 1, 1);
    chk("R6 loop 1 locks", share_out, 1);
    pwr_on = 2'b11;
    @(negedge clk);
    chk("R8 AND with unlocked loop 0", share_out, 0);
    chk("R7 loop 0 restarts unlocked", share_out, 0);
    compare(0, 1, 1); compare(0, 1, 1); compare(0, 1, 1);
    chk("R8 both locked", share_out, 1);
    repeat (2) @(negedge clk);

    chk("R1 no leftover loop 0 items", q0.size(), 0);
    chk("R1 no leftover loop 1 items", q1.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule